// File: doc/BRIEF.md
# Variable-Page TLB Lookup Unit

A fully associative address-translation buffer for a small processor memory-management unit. Every entry holds a tag word, a data word and an 8-bit translation ID. The tag word gives the effective page number, a 3-bit page-size code and a valid bit. The data word gives the real page number, a write-enable bit, an execute-enable bit and a 4-bit zone select. Each entry has its own page size, from 1 KB up to 16 MB.

A lookup presents a virtual address, an access kind and a privilege level with a one-cycle request strobe. The search is combinational. Its result is registered, so status, matched index, physical address and page-size code are valid one cycle after the strobe. The result holds until the next strobe. A 32-bit zone protection input gives a 2-bit field per zone. This field can hide an entry from user accesses or grant write and execute rights. Entries are loaded one word at a time through a write port. Refill and page-table walking are handled outside the unit.

Top module: `vpt_tlb`

## Requirements
- R1: Page-size field. Tag bits [9:7] hold a size code c that selects a page of 1 KB << (2*c), so codes 0..7 give 1 KB through 16 MB. On a hit or a fault, size_o reports c.
- R2: Entry match. An entry takes part in the search only when tag bit [6] (valid) is set and the virtual address equals tag bits [31:10], both compared only above the page-offset bits.
- R3: Translation ID. A tag-word write stores pid_i as the entry's translation ID. An ID of zero matches any pid_i. A nonzero ID must equal pid_i at lookup time, or the entry is skipped.
- R4: Zone field 00 skips the entry for user accesses (user_i=1) and the search continues with higher entries. For supervisor accesses the entry's own bits apply.
- R5: The zone field for zone select z is zone_prot_i[31-2z:30-2z]. Field 01 uses the entry's write bit (data bit 8) and execute bit (data bit 9). Field 10 grants write and execute to supervisor accesses only. Field 11 grants both to every access.
- R6: A zone select greater than the ZONE_CNT parameter (default 8) is treated as field 01, while select equal to ZONE_CNT still reads the register. With the PROT_LITE parameter set, every field is treated as 01.
- R7: Access kind kind_i is 0 for read, 1 for write, 2 for execute, and 3 is treated as read. Read is always allowed. For the first matching entry, a write without write rights or an execute without execute rights gives status 2 (fault), with idx_o set to that entry and paddr_o set to 0. Higher-indexed entries are not consulted.
- R8: Status is 0 for miss, 1 for hit and 2 for fault, and never 3. On a miss, idx_o, paddr_o and size_o are 0.
- R9: When several entries match, the lowest index decides the result.
- R10: On a hit, paddr_o takes the real page number (data bits [31:10]) above the page-offset bits and the virtual address below them. idx_o gives the entry.
- R11: rsp_valid_o is high exactly in the cycle after each cycle with req_i high. The result outputs change only on a request and hold their values otherwise.
- R12: After reset, every entry is invalid, rsp_valid_o is 0 and the result outputs read as a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pid_i | input | 8 | Current process ID |
| zone_prot_i | input | 32 | Zone protection fields, 2 bits per zone, zone 0 at the top |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_word_i | input | 1 | 0 selects the tag word, 1 selects the data word |
| wr_idx_i | input | IW | Entry index to write |
| wr_data_i | input | 32 | Word to write |
| req_i | input | 1 | Lookup strobe |
| vaddr_i | input | 32 | Virtual address |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| user_i | input | 1 | 1 for a user-mode access |
| rsp_valid_o | output | 1 | Result valid, one cycle after req_i |
| status_o | output | 2 | 0 miss, 1 hit, 2 fault |
| idx_o | output | IW | Matching entry index |
| paddr_o | output | 32 | Translated physical address |
| size_o | output | 3 | Page-size code of the matching entry |

## Verification
A bad stored tag, size code or translation ID shows up on the first lookup that touches the entry. The symptom is a wrong status or index, or the wrong split between page bits and offset bits in paddr_o, visible one cycle after the strobe. A wrong zone decode shows as a hit where a fault was due, or as the wrong entry winning after a skip. Several entries share an address in the tests, so priority and skip errors change idx_o at once. A stale or unheld result register shows in the cycles between strobes, when the outputs must stay still and rsp_valid_o must stay low.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_HIT   = 2'd1,
    ST_FAULT = 2'd2
  } tlb_status_e;

  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_EXEC  = 2'd2;

  localparam int TAG_VALID_BIT = 6;
  localparam int DATA_WR_BIT   = 8;
  localparam int DATA_EX_BIT   = 9;
  localparam logic [31:0] PAGE_NUM_MASK = 32'hFFFF_FC00;

  // Keep bits above the page offset; offset is 10 + 2*code bits wide.
  function automatic logic [31:0] page_mask(input logic [2:0] code);
    return 32'hFFFF_FFFF << (32'd10 + 32'(code) * 32'd2);
  endfunction
endpackage

// File: rtl/vpt_tlb_zone.sv
module vpt_tlb_zone #(
  parameter int unsigned ZONE_CNT  = 8,
  parameter bit          PROT_LITE = 1'b0
) (
  input  logic [3:0]  zsel_i,
  input  logic [31:0] zone_prot_i,
  output logic [1:0]  field_o
);
  generate
    if (PROT_LITE) begin : g_lite
      logic unused_w;
      assign unused_w = ^{zsel_i, zone_prot_i};
      assign field_o  = 2'b01;
    end else begin : g_full
      logic [31:0] sh_w;
      always_comb begin
        sh_w = zone_prot_i >> (5'd30 - {zsel_i, 1'b0});
        if (32'(zsel_i) > ZONE_CNT) field_o = 2'b01;
        else                        field_o = sh_w[1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
  import vpt_tlb_pkg::*;
#(
  parameter int unsigned ZONE_CNT  = 8,
  parameter bit          PROT_LITE = 1'b0
) (
  input  logic [31:0] tag_i,
  input  logic        wr_bit_i,
  input  logic        ex_bit_i,
  input  logic [3:0]  zsel_i,
  input  logic [7:0]  tid_i,
  input  logic [7:0]  pid_i,
  input  logic [31:0] zone_prot_i,
  input  logic [31:0] vaddr_i,
  input  logic        user_i,
  output logic        cand_o,
  output logic        wr_ok_o,
  output logic        ex_ok_o
);
  logic [1:0]  field_w;
  logic [31:0] mask_w;
  logic        addr_eq_w, tid_ok_w, hidden_w;

  vpt_tlb_zone #(.ZONE_CNT(ZONE_CNT), .PROT_LITE(PROT_LITE)) u_zone (
    .zsel_i      (zsel_i),
    .zone_prot_i (zone_prot_i),
    .field_o     (field_w)
  );

  always_comb begin
    mask_w    = page_mask(tag_i[9:7]);
    addr_eq_w = ((vaddr_i ^ tag_i) & mask_w) == 32'd0;
    tid_ok_w  = (tid_i == 8'd0) || (tid_i == pid_i);
    hidden_w  = (field_w == 2'b00) && user_i;
    cand_o    = tag_i[TAG_VALID_BIT] && addr_eq_w && tid_ok_w && !hidden_w;
    wr_ok_o   = wr_bit_i || (field_w == 2'b11) || ((field_w == 2'b10) && !user_i);
    ex_ok_o   = ex_bit_i || (field_w == 2'b11) || ((field_w == 2'b10) && !user_i);
  end
endmodule

// File: rtl/vpt_tlb_pick.sv
module vpt_tlb_pick #(
  parameter int N_ENTRIES = 64,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] cand_i,
  output logic                 any_o,
  output logic [IW-1:0]        idx_o
);
  // Scan downward so the lowest set index is the last one written.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_tlb_pkg::*;
#(
  parameter int          N_ENTRIES = 64,
  parameter int unsigned ZONE_CNT  = 8,
  parameter bit          PROT_LITE = 1'b0,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    pid_i,
  input  logic [31:0]   zone_prot_i,
  input  logic          wr_en_i,
  input  logic          wr_word_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [31:0]   wr_data_i,
  input  logic          req_i,
  input  logic [31:0]   vaddr_i,
  input  logic [1:0]    kind_i,
  input  logic          user_i,
  output logic          rsp_valid_o,
  output logic [1:0]    status_o,
  output logic [IW-1:0] idx_o,
  output logic [31:0]   paddr_o,
  output logic [2:0]    size_o
);
  logic [31:0] tag_q  [N_ENTRIES];
  logic [31:0] data_q [N_ENTRIES];
  logic [7:0]  tid_q  [N_ENTRIES];

  logic [N_ENTRIES-1:0] cand_w, wr_ok_w, ex_ok_w;
  logic                 any_w;
  logic [IW-1:0]        sel_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        tid_q[i]  <= '0;
      end
    end else if (wr_en_i && (32'(wr_idx_i) < N_ENTRIES)) begin
      if (!wr_word_i) begin
        tag_q[wr_idx_i] <= wr_data_i;
        tid_q[wr_idx_i] <= pid_i;
      end else begin
        data_q[wr_idx_i] <= wr_data_i;
      end
    end
  end

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      vpt_tlb_match #(.ZONE_CNT(ZONE_CNT), .PROT_LITE(PROT_LITE)) u_match (
        .tag_i       (tag_q[g]),
        .wr_bit_i    (data_q[g][DATA_WR_BIT]),
        .ex_bit_i    (data_q[g][DATA_EX_BIT]),
        .zsel_i      (data_q[g][7:4]),
        .tid_i       (tid_q[g]),
        .pid_i       (pid_i),
        .zone_prot_i (zone_prot_i),
        .vaddr_i     (vaddr_i),
        .user_i      (user_i),
        .cand_o      (cand_w[g]),
        .wr_ok_o     (wr_ok_w[g]),
        .ex_ok_o     (ex_ok_w[g])
      );
    end
  endgenerate

  vpt_tlb_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .cand_i (cand_w),
    .any_o  (any_w),
    .idx_o  (sel_w)
  );

  tlb_status_e status_d;
  logic [31:0] sel_tag_w, sel_data_w, mask_w, paddr_d;
  logic [IW-1:0] idx_d;
  logic [2:0]  size_d;
  logic        fault_w;

  always_comb begin
    sel_tag_w  = tag_q[sel_w];
    sel_data_w = data_q[sel_w];
    mask_w     = page_mask(sel_tag_w[9:7]);
    fault_w    = ((kind_i == KIND_WRITE) && !wr_ok_w[sel_w]) ||
                 ((kind_i == KIND_EXEC)  && !ex_ok_w[sel_w]);
    status_d   = !any_w ? ST_MISS : (fault_w ? ST_FAULT : ST_HIT);
    idx_d      = any_w ? sel_w : '0;
    size_d     = any_w ? sel_tag_w[9:7] : 3'd0;
    paddr_d    = (status_d == ST_HIT) ?
                 ((sel_data_w & PAGE_NUM_MASK & mask_w) | (vaddr_i & ~mask_w)) : 32'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      status_o    <= ST_MISS;
      idx_o       <= '0;
      paddr_o     <= '0;
      size_o      <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        status_o <= status_d;
        idx_o    <= idx_d;
        paddr_o  <= paddr_d;
        size_o   <= size_d;
      end
    end
  end
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
  parameter int IW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [9:0]    voff_i,
  input logic          rsp_valid_o,
  input logic [1:0]    status_o,
  input logic [IW-1:0] idx_o,
  input logic [31:0]   paddr_o,
  input logic [2:0]    size_o
);
  assert_rsp_after_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_rsp_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(status_o) && $stable(idx_o) && $stable(paddr_o) && $stable(size_o)));
  assert_status_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
  assert_miss_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0) |-> (idx_o == '0 && paddr_o == 32'd0 && size_o == 3'd0));
  assert_fault_no_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd2) |-> (paddr_o == 32'd0));
  assert_offset_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (status_o != 2'd1 || paddr_o[9:0] == $past(voff_i)));
endmodule

bind vpt_tlb vpt_tlb_chk #(.IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .voff_i      (vaddr_i[9:0]),
  .rsp_valid_o (rsp_valid_o),
  .status_o    (status_o),
  .idx_o       (idx_o),
  .paddr_o     (paddr_o),
  .size_o      (size_o)
);

// File: tb/vpt_tlb_test.sv
module vpt_tlb_test;
  localparam int CLK_NS = 10;
  localparam logic [1:0] MISS = 2'd0, HIT = 2'd1, FLT = 2'd2;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  typedef struct packed {
    logic [1:0]  st;
    logic [5:0]  idx;
    logic [31:0] pa;
    logic [2:0]  sz;
    logic [7:0]  rq;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pid = '0;
  logic [31:0] zpr = 32'h52C0_3000;
  logic wr_en = 1'b0, wr_word = 1'b0;
  logic [5:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic req = 1'b0;
  logic [31:0] va = '0;
  logic [1:0] kind = '0;
  logic user = 1'b0;

  logic rv, rv_l;
  logic [1:0] st, st_l;
  logic [5:0] idx, idx_l;
  logic [31:0] pa, pa_l;
  logic [2:0] sz, sz_l;

  int total = 0, bad = 0;
  exp_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  vpt_tlb uut (
    .clk_i(clk), .rst_ni(rst_n), .pid_i(pid), .zone_prot_i(zpr),
    .wr_en_i(wr_en), .wr_word_i(wr_word), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .req_i(req), .vaddr_i(va), .kind_i(kind), .user_i(user),
    .rsp_valid_o(rv), .status_o(st), .idx_o(idx), .paddr_o(pa), .size_o(sz)
  );

  vpt_tlb #(.PROT_LITE(1'b1)) uut_lite (
    .clk_i(clk), .rst_ni(rst_n), .pid_i(pid), .zone_prot_i(zpr),
    .wr_en_i(wr_en), .wr_word_i(wr_word), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .req_i(req), .vaddr_i(va), .kind_i(kind), .user_i(user),
    .rsp_valid_o(rv_l), .status_o(st_l), .idx_o(idx_l), .paddr_o(pa_l), .size_o(sz_l)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (rst_n && rv) begin
      if (sb.size() == 0) begin
        chk("R11", "unexpected rsp", 32'd1, 32'd0);
      end else begin
        exp_t e;
        string r;
        e = sb.pop_front();
        r = $sformatf("R%0d", e.rq);
        chk(r, "status", 32'(st), 32'(e.st));
        chk(r, "idx", 32'(idx), 32'(e.idx));
        chk(r, "paddr", pa, e.pa);
        chk(r, "size", 32'(sz), 32'(e.sz));
      end
    end
  end

  task automatic wr_word_t(input logic [5:0] i, input logic w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [5:0] i, input logic [31:0] t, input logic [31:0] d);
    wr_word_t(i, 1'b0, t);
    wr_word_t(i, 1'b1, d);
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] k, input logic u,
                        input logic [1:0] es, input logic [5:0] ei, input logic [31:0] ep,
                        input logic [2:0] ez, input logic [7:0] rq);
    sb.push_back('{st: es, idx: ei, pa: ep, sz: ez, rq: rq});
    @(negedge clk);
    va = a; kind = k; user = u; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "rsp_valid in reset", 32'(rv), 32'd0);
    chk("R12", "status in reset", 32'(st), 32'(MISS));
    rst_n = 1'b1;
    // R12, R8: empty table misses
    lookup(32'h0001_2345, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd12);

    // R1, R10, R7: 4 KB page, write-enabled, no execute, zone 0 (field 01)
    load(6'd5, 32'h0001_20C0, 32'h8000_0100);
    lookup(32'h0001_2345, RD, 1'b0, HIT, 6'd5, 32'h8000_0345, 3'd1, 8'd10);
    lookup(32'h0001_2FFF, WR, 1'b1, HIT, 6'd5, 32'h8000_0FFF, 3'd1, 8'd7);
    lookup(32'h0001_2345, EX, 1'b0, FLT, 6'd5, 32'd0, 3'd1, 8'd7);
    lookup(32'h0001_2345, 2'd3, 1'b0, HIT, 6'd5, 32'h8000_0345, 3'd1, 8'd7);
    lookup(32'h0001_3000, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd2);   // R2

    // R1, R10: 16 MB page, RPN low bits ignored
    load(6'd9, 32'h0300_03C0, 32'h4012_3710);
    lookup(32'h03AB_CDEF, EX, 1'b1, HIT, 6'd9, 32'h40AB_CDEF, 3'd7, 8'd1);
    lookup(32'h0400_0000, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd2);
    lookup(32'h02FF_FFFF, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd2);
    // R1: 1 KB page
    load(6'd12, 32'h0000_0440, 32'h0000_0F10);
    lookup(32'h0000_07FF, RD, 1'b0, HIT, 6'd12, 32'h0000_0FFF, 3'd0, 8'd1);
    lookup(32'h0000_0800, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd2);

    // R3: translation ID
    pid = 8'h22;
    load(6'd20, 32'h0050_00C0, 32'h0060_0310);
    lookup(32'h0050_0ABC, RD, 1'b0, HIT, 6'd20, 32'h0060_0ABC, 3'd1, 8'd3);
    pid = 8'h33;
    lookup(32'h0050_0ABC, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd3);
    lookup(32'h0001_2345, RD, 1'b0, HIT, 6'd5, 32'h8000_0345, 3'd1, 8'd3);
    pid = 8'h00;
    lookup(32'h0050_0ABC, RD, 1'b0, MISS, 6'd0, 32'd0, 3'd0, 8'd3);

    // R9: lowest index wins; R2: invalid entry drops out
    load(6'd31, 32'h0070_00C0, 32'h0B00_0310);
    load(6'd30, 32'h0070_00C0, 32'h0A00_0310);
    lookup(32'h0070_0123, RD, 1'b0, HIT, 6'd30, 32'h0A00_0123, 3'd1, 8'd9);
    wr_word_t(6'd30, 1'b0, 32'h0070_0080);
    lookup(32'h0070_0123, RD, 1'b0, HIT, 6'd31, 32'h0B00_0123, 3'd1, 8'd2);

    // R4: zone 2 field 00 hides entry 40 from user
    load(6'd40, 32'h0090_00C0, 32'h0C00_0020);
    load(6'd41, 32'h0090_00C0, 32'h0D00_0310);
    lookup(32'h0090_0456, RD, 1'b1, HIT, 6'd41, 32'h0D00_0456, 3'd1, 8'd4);
    chk("R6", "lite idx", 32'(idx_l), 32'd40);
    lookup(32'h0090_0456, RD, 1'b0, HIT, 6'd40, 32'h0C00_0456, 3'd1, 8'd4);
    lookup(32'h0090_0456, WR, 1'b0, FLT, 6'd40, 32'd0, 3'd1, 8'd7);
    lookup(32'h0090_0456, WR, 1'b1, HIT, 6'd41, 32'h0D00_0456, 3'd1, 8'd4);

    // R5: zone 3 field 10, zone 4 field 11
    load(6'd50, 32'h00A0_00C0, 32'h0E00_0030);
    lookup(32'h00A0_0010, WR, 1'b0, HIT, 6'd50, 32'h0E00_0010, 3'd1, 8'd5);
    lookup(32'h00A0_0010, EX, 1'b0, HIT, 6'd50, 32'h0E00_0010, 3'd1, 8'd5);
    lookup(32'h00A0_0010, WR, 1'b1, FLT, 6'd50, 32'd0, 3'd1, 8'd5);
    lookup(32'h00A0_0010, RD, 1'b1, HIT, 6'd50, 32'h0E00_0010, 3'd1, 8'd5);
    load(6'd51, 32'h00B0_00C0, 32'h0F00_0040);
    lookup(32'h00B0_0020, EX, 1'b1, HIT, 6'd51, 32'h0F00_0020, 3'd1, 8'd5);
    chk("R6", "lite status", 32'(st_l), 32'(FLT));

    // R6: zone 9 beyond count reads as 01; zone 8 still uses register (00)
    load(6'd52, 32'h00C0_00C0, 32'h0110_0090);
    lookup(32'h00C0_0000, WR, 1'b1, FLT, 6'd52, 32'd0, 3'd1, 8'd6);
    lookup(32'h00C0_0000, WR, 1'b0, FLT, 6'd52, 32'd0, 3'd1, 8'd6);
    load(6'd53, 32'h00D0_00C0, 32'h0120_0380);
    lookup(32'h00D0_0000, RD, 1'b1, MISS, 6'd0, 32'd0, 3'd0, 8'd6);
    lookup(32'h00D0_0000, WR, 1'b0, HIT, 6'd53, 32'h0120_0000, 3'd1, 8'd6);

    // R11: result holds while idle
    va = 32'h0000_0000; kind = EX; user = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "idle rsp_valid", 32'(rv), 32'd0);
    chk("R11", "held status", 32'(st), 32'(HIT));
    chk("R11", "held paddr", pa, 32'h0120_0000);
    chk("R11", "pending", 32'(sb.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule